// File: doc/BRIEF.md
# ATM receive OAM cell router

This block sits in an ATM receive path after cell delineation. It takes whole 53-byte cells as a byte stream. A start-of-cell marker flags the first header byte. The block reads the first four header bytes and sorts the cell into one of these kinds: user data, idle, F4 OAM or F5 OAM. An OAM cell is also marked as segment or end-to-end. From that result the block steers the cell. It can forward the cell whole to the receive FIFO write port, or drop it. Independently of that choice, it can copy an OAM cell into a one-cell buffer that a microprocessor reads. A finished copy raises an interrupt.

Both the input and the output are valid/ready byte streams. A byte moves when valid and ready are both high at a rising clock edge. The four header bytes are held inside the block until the decision is made. While they are replayed to the output, the input ready is low. For the rest of a forwarded cell, the input ready follows the output ready, so back-pressure passes straight through. A dropped cell never waits on the output ready. The configuration pins, the filter range, the buffer read port and the interrupt pins are plain levels.

Top module: `atm_oam_router`

## Requirements
- R1: The header is read as GFC[31:28], VPI[27:20], VCI[19:4], PTI[3:1] and CLP[0] of the 32-bit word made from header bytes 0..3, with byte 0 as the most significant. The header 00 00 00 01 is idle. VCI 3 is F4 segment OAM and VCI 4 is F4 end-to-end OAM. Otherwise, PTI 100 is F5 segment OAM and PTI 101 is F5 end-to-end OAM.
- R2: A user cell or an end-to-end OAM cell is forwarded as all 53 bytes, unchanged and in order. `out_soc` is high on the first byte only.
- R3: A segment OAM cell is not forwarded when it misses the user filter.
- R4: With `flt_en` high, a cell whose 32-bit header lies in the inclusive range [`flt_lo`, `flt_hi`] is forwarded even if it is segment OAM. The filter does not override the idle-discard drop or the HEC drop.
- R5: With `cfg_oam_check` high, every OAM cell that is not HEC-dropped is copied, all 53 bytes, into the OAM buffer. This includes dropped segment cells. Buffer byte k is the cell's byte k. `rd_data` returns the byte at `rd_addr` one cycle after the address is presented.
- R6: `irq` rises in the cycle after the edge that accepts the last byte of a copied cell. It stays high until `irq_clr` is pulsed. It is low after reset.
- R7: With `cfg_oam_check` low, no cell is copied, the buffer keeps its contents and `irq` does not rise.
- R8: With `cfg_idle_discard` high, idle cells are dropped. With it low, they are forwarded.
- R9: `in_hec_err` is sampled with the start-of-cell byte. A flagged cell is dropped and never copied when `cfg_hec_ignore` is low, and is processed normally when it is high.
- R10: A copy that completes while `irq` is pending overwrites the buffer and sets `oam_ovr`. `irq_clr` clears both `irq` and `oam_ovr`.
- R11: A stalled output byte is held stable. A dropped cell is taken at one byte per cycle (53 bytes plus 4 internal cycles) even while `out_ready` is low.
- R12: Bytes that arrive outside a cell, before any start-of-cell marker, are accepted and ignored.
- R13: The configuration pins and the filter are sampled when the fourth header byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be taken |
| in_data | input | 8 | Input cell byte |
| in_soc | input | 1 | Input byte is byte 0 of a cell |
| in_hec_err | input | 1 | HEC error flag, qualified with the start-of-cell byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_ready | input | 1 | FIFO write port can take a byte |
| out_data | output | 8 | Forwarded cell byte |
| out_soc | output | 1 | Forwarded byte is byte 0 of a cell |
| cfg_hec_ignore | input | 1 | Process cells with a HEC error |
| cfg_oam_check | input | 1 | Copy OAM cells to the buffer |
| cfg_idle_discard | input | 1 | Drop idle cells |
| flt_en | input | 1 | User filter enable |
| flt_lo | input | 32 | Filter range low header |
| flt_hi | input | 32 | Filter range high header |
| rd_addr | input | 6 | OAM buffer read address |
| rd_data | output | 8 | OAM buffer read data, one cycle latency |
| irq | output | 1 | Received-OAM-cell interrupt |
| irq_clr | input | 1 | Clears irq and oam_ovr |
| oam_ovr | output | 1 | Sticky buffer overrun flag |

## Verification
Forwarded header bytes begin in the cycle after the fourth header byte is accepted. Each body byte appears at the output in the same cycle it is offered at the input. `irq` and `oam_ovr` change one cycle after the edge that accepts the last cell byte. `rd_data` is due one cycle after `rd_addr`. The bench drives its inputs just after a rising edge. It records each output handshake at the falling edge before the edge that completes it. It checks the interrupt pins and the buffer only after a settling gap following the last byte, and it reads the buffer one edge after setting the address. This makes every comparison land in the cycle where that result is due.

// File: rtl/atm_oam_pkg.sv
package atm_oam_pkg;
  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {S_HUNT, S_HDR, S_DRAIN, S_BODY} steer_state_e;

  typedef struct packed {
    logic idle;
    logic oam;
    logic seg;
  } cell_class_t;
endpackage

// File: rtl/atm_hdr_classify.sv
module atm_hdr_classify
  import atm_oam_pkg::*;
#(
  parameter int HDR_W       = 32,
  parameter int F4_SEG_VCI  = 3,
  parameter int F4_E2E_VCI  = 4,
  parameter logic [2:0] F5_SEG_PTI = 3'b100,
  parameter logic [2:0] F5_E2E_PTI = 3'b101
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic             flt_en,
  input  logic [HDR_W-1:0] flt_lo,
  input  logic [HDR_W-1:0] flt_hi,
  output cell_class_t      cls,
  output logic             flt_hit
);
  localparam int VCI_LSB = 4;
  localparam int VCI_W   = 16;
  localparam int PTI_LSB = 1;
  localparam logic [HDR_W-1:0] IDLE_HDR = HDR_W'(1);

  logic [VCI_W-1:0] vci;
  logic [2:0]       pti;
  logic             f4_seg, f4_e2e, f5_seg, f5_e2e, is_f4;

  assign vci    = hdr[VCI_LSB +: VCI_W];
  assign pti    = hdr[PTI_LSB +: 3];
  assign f4_seg = (vci == VCI_W'(F4_SEG_VCI));
  assign f4_e2e = (vci == VCI_W'(F4_E2E_VCI));
  assign is_f4  = f4_seg | f4_e2e;
  assign f5_seg = !is_f4 && (pti == F5_SEG_PTI);
  assign f5_e2e = !is_f4 && (pti == F5_E2E_PTI);

  always_comb begin
    cls.idle = (hdr == IDLE_HDR);
    cls.oam  = !cls.idle && (is_f4 | f5_seg | f5_e2e);
    cls.seg  = f4_seg | f5_seg;
  end

  assign flt_hit = flt_en && (hdr >= flt_lo) && (hdr <= flt_hi);
endmodule

// File: rtl/atm_oam_buffer.sv
module atm_oam_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 53,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_clr,
  output logic              irq,
  output logic              ovr
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (commit)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      ovr <= (irq_clr ? 1'b0 : ovr) | (commit & irq & !irq_clr);
    end
  end

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && irq && !irq_clr) |=> ovr);
  p_ovr_needs_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> irq);
endmodule

// File: rtl/atm_cell_steer.sv
module atm_cell_steer
  import atm_oam_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  localparam int IDX_W     = $clog2(CELL_BYTES),
  localparam int HDR_W     = HDR_BYTES * DATA_W,
  localparam int DIDX_W    = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_soc,
  input  logic              in_hec_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_soc,
  input  logic              cfg_hec_ignore,
  input  logic              cfg_oam_check,
  input  logic              cfg_idle_discard,
  output logic [HDR_W-1:0]  hdr_cand,
  input  cell_class_t       cls,
  input  logic              flt_hit,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_waddr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              copy_done
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0]  HDR_LAST  = IDX_W'(HDR_BYTES - 1);
  localparam logic [DIDX_W-1:0] DRN_LAST  = DIDX_W'(HDR_BYTES - 1);

  steer_state_e      state;
  logic [DATA_W-1:0] hdr_q [HDR_BYTES];
  logic [IDX_W-1:0]  cnt;
  logic [DIDX_W-1:0] didx;
  logic              hec_q, fwd_q, copy_q, seg_q;
  logic              in_acc, drain_step, hec_drop, fwd_d, copy_d, decide;

  always_comb begin
    for (int i = 0; i < HDR_BYTES - 1; i++)
      hdr_cand[HDR_W-1-i*DATA_W -: DATA_W] = hdr_q[i];
    hdr_cand[DATA_W-1:0] = in_data;
  end

  assign hec_drop = hec_q & !cfg_hec_ignore;
  assign fwd_d    = !hec_drop && !(cls.idle && cfg_idle_discard) &&
                    (flt_hit || !(cls.oam && cls.seg));
  assign copy_d   = !hec_drop && cls.oam && cfg_oam_check;

  always_comb begin
    unique case (state)
      S_DRAIN: in_ready = 1'b0;
      S_BODY:  in_ready = fwd_q ? out_ready : 1'b1;
      default: in_ready = 1'b1;
    endcase
  end

  assign in_acc     = in_valid && in_ready;
  assign decide     = (state == S_HDR) && in_acc && (cnt == HDR_LAST);
  assign drain_step = (state == S_DRAIN) && (!fwd_q || out_ready);
  assign out_valid  = fwd_q && ((state == S_DRAIN) || ((state == S_BODY) && in_valid));
  assign out_data   = (state == S_DRAIN) ? hdr_q[didx] : in_data;
  assign out_soc    = (state == S_DRAIN) && fwd_q && (didx == '0);
  assign buf_we     = copy_q && (drain_step || ((state == S_BODY) && in_acc));
  assign buf_waddr  = (state == S_DRAIN) ? IDX_W'(didx) : cnt;
  assign buf_wdata  = out_data;
  assign copy_done  = copy_q && (state == S_BODY) && in_acc && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_HUNT;
      cnt    <= '0;
      didx   <= '0;
      hec_q  <= 1'b0;
      fwd_q  <= 1'b0;
      copy_q <= 1'b0;
      seg_q  <= 1'b0;
    end else begin
      unique case (state)
        S_HUNT: if (in_acc && in_soc) begin
          hdr_q[0] <= in_data;
          hec_q    <= in_hec_err;
          cnt      <= IDX_W'(1);
          state    <= S_HDR;
        end
        S_HDR: if (in_acc) begin
          hdr_q[cnt[DIDX_W-1:0]] <= in_data;
          if (cnt == HDR_LAST) begin
            fwd_q  <= fwd_d;
            copy_q <= copy_d;
            seg_q  <= cls.oam && cls.seg && !flt_hit;
            didx   <= '0;
            state  <= S_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRAIN: if (drain_step) begin
          if (didx == DRN_LAST) begin
            cnt   <= IDX_W'(HDR_BYTES);
            state <= S_BODY;
          end else begin
            didx <= didx + 1'b1;
          end
        end
        S_BODY: if (in_acc) begin
          if (cnt == LAST_IDX) state <= S_HUNT;
          else                 cnt   <= cnt + 1'b1;
        end
        default: state <= S_HUNT;
      endcase
    end
  end

  p_seg_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_DRAIN) && seg_q) |-> !out_valid);
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_no_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !cfg_oam_check) |=> !buf_we);
  p_hec_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && hec_q && !cfg_hec_ignore) |=> (!out_valid && !buf_we));
  p_soc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_soc && out_ready) |=> !out_soc);
endmodule

// File: rtl/atm_oam_router.sv
module atm_oam_router
  import atm_oam_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  localparam int IDX_W     = $clog2(CELL_BYTES),
  localparam int HDR_W     = HDR_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_soc,
  input  logic              in_hec_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_soc,
  input  logic              cfg_hec_ignore,
  input  logic              cfg_oam_check,
  input  logic              cfg_idle_discard,
  input  logic              flt_en,
  input  logic [HDR_W-1:0]  flt_lo,
  input  logic [HDR_W-1:0]  flt_hi,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  input  logic              irq_clr,
  output logic              oam_ovr
);
  logic [HDR_W-1:0]  hdr_cand;
  cell_class_t       cls;
  logic              flt_hit, buf_we, copy_done;
  logic [IDX_W-1:0]  buf_waddr;
  logic [DATA_W-1:0] buf_wdata;

  atm_hdr_classify #(.HDR_W(HDR_W)) u_cls (
    .hdr(hdr_cand), .flt_en(flt_en), .flt_lo(flt_lo), .flt_hi(flt_hi),
    .cls(cls), .flt_hit(flt_hit)
  );

  atm_cell_steer #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_soc(in_soc), .in_hec_err(in_hec_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_soc(out_soc),
    .cfg_hec_ignore(cfg_hec_ignore), .cfg_oam_check(cfg_oam_check),
    .cfg_idle_discard(cfg_idle_discard),
    .hdr_cand(hdr_cand), .cls(cls), .flt_hit(flt_hit),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .copy_done(copy_done)
  );

  atm_oam_buffer #(.DATA_W(DATA_W), .DEPTH(CELL_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
    .commit(copy_done), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_clr(irq_clr), .irq(irq), .ovr(oam_ovr)
  );

  p_reset_quiet_r6: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq && !oam_ovr && !out_valid));
endmodule

// File: tb/tb_atm_oam_router.sv
module tb_atm_oam_router;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, in_soc = 0, in_hec_err = 0;
  logic [7:0]  in_data = 0, out_data, rd_data;
  logic        out_valid, out_ready = 1, out_soc;
  logic        cfg_hec_ignore = 0, cfg_oam_check = 0, cfg_idle_discard = 0;
  logic        flt_en = 0, irq, irq_clr = 0, oam_ovr;
  logic [31:0] flt_lo = 32'h0010_0000, flt_hi = 32'h001F_FFFF;
  logic [5:0]  rd_addr = 0;

  int checks = 0, fails = 0, cyc = 0, bp_mode = 0;
  int got_n = 0, soc_n = 0, soc_pos = -1;
  logic [7:0] got [64];
  logic       have_copy = 0;
  int         last_id = 0;
  logic [31:0] last_hdr = 0;

  atm_oam_router dut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (bp_mode == 0)      out_ready = 1'b1;
    else if (bp_mode == 1) out_ready = (cyc % 3) != 0;
    else                   out_ready = 1'b0;
  end

  always @(negedge clk) if (out_valid && out_ready) begin
    if (got_n < 64) got[got_n] = out_data;
    if (out_soc) begin soc_n++; soc_pos = got_n; end
    got_n++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, act timeout exp completion");
    summary();
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int id, input logic [31:0] h, input int i);
    if (i < 4)       return h[31-8*i -: 8];
    else if (i == 4) return 8'hA5 ^ 8'(id);
    else             return 8'(id * 7 + i);
  endfunction

  task automatic put_byte(input logic [7:0] d, input logic s, input logic h);
    in_valid = 1; in_data = d; in_soc = s; in_hec_err = h;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_soc = 0; in_hec_err = 0;
  endtask

  task automatic send_cell(input int id, input logic [31:0] h, input logic herr);
    got_n = 0; soc_n = 0; soc_pos = -1;
    for (int i = 0; i < 53; i++) put_byte(exp_byte(id, h, i), i == 0, herr);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    rd_addr = 6'(a);
    @(posedge clk); @(negedge clk);
    v = rd_data;
    @(posedge clk); #1;
  endtask

  task automatic pulse_clr();
    irq_clr = 1; @(posedge clk); #1; irq_clr = 0;
  endtask

  task automatic check_fwd(input string req, input int id, input logic [31:0] h, input logic fwd);
    logic ok;
    chk(got_n == (fwd ? 53 : 0), req, 32'(got_n), fwd ? 53 : 0);
    if (fwd) begin
      ok = 1;
      for (int i = 0; i < 53; i++) if (got[i] !== exp_byte(id, h, i)) ok = 0;
      chk(ok, {req, " R2 content"}, {24'h0, got[52]}, {24'h0, exp_byte(id, h, 52)});
      chk(soc_n == 1 && soc_pos == 0, "R2 soc on byte 0", 32'(soc_pos), 0);
    end
  endtask

  task automatic check_buf(input string req);
    logic [7:0] v;
    if (have_copy) begin
      rd(0, v);  chk(v === last_hdr[31:24], req, {24'h0, v}, {24'h0, last_hdr[31:24]});
      rd(3, v);  chk(v === last_hdr[7:0], req, {24'h0, v}, {24'h0, last_hdr[7:0]});
      rd(52, v); chk(v === exp_byte(last_id, last_hdr, 52), req, {24'h0, v},
                     {24'h0, exp_byte(last_id, last_hdr, 52)});
    end
  endtask

  // {hdr[43:12], hec_err[11], cfg {idle_dis,oam_chk,hec_ign}[10:8], flt_en[7], fwd[6], copy[5], pad[4:0]}
  localparam logic [43:0] VEC [13] = '{
    {32'h0020_0200, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 5'd0}, // R2 user cell
    {32'h0020_0030, 1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 5'd0}, // R1 R3 F4 segment
    {32'h0020_0040, 1'b0, 3'b010, 1'b0, 1'b1, 1'b1, 5'd0}, // R1 F4 end-to-end
    {32'h0020_0208, 1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 5'd0}, // R1 R3 F5 segment
    {32'h0020_020A, 1'b0, 3'b010, 1'b0, 1'b1, 1'b1, 5'd0}, // R1 F5 end-to-end
    {32'h0020_0030, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 5'd0}, // R7 no copy
    {32'h0010_0208, 1'b0, 3'b010, 1'b1, 1'b1, 1'b1, 5'd0}, // R4 filter wins
    {32'h0010_0208, 1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 5'd0}, // R4 filter off
    {32'h0000_0001, 1'b0, 3'b110, 1'b0, 1'b0, 1'b0, 5'd0}, // R8 idle dropped
    {32'h0000_0001, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 5'd0}, // R8 idle kept
    {32'h0020_0200, 1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 5'd0}, // R9 hec drop
    {32'h0020_0200, 1'b1, 3'b011, 1'b0, 1'b1, 1'b0, 5'd0}, // R9 hec ignore
    {32'h0020_0040, 1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 5'd0}  // R9 hec drop OAM
  };

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R6 reset state
    chk(!irq && !oam_ovr && !out_valid && in_ready, "R6 reset state",
        {29'h0, irq, oam_ovr, out_valid}, 0);
    @(posedge clk); #1;

    for (int v = 0; v < 13; v++) begin
      logic [31:0] h;
      h = VEC[v][43:12];
      cfg_idle_discard = VEC[v][10]; cfg_oam_check = VEC[v][9]; cfg_hec_ignore = VEC[v][8];
      flt_en = VEC[v][7];
      bp_mode = v % 2;
      send_cell(v + 1, h, VEC[v][11]);
      bp_mode = 0;
      check_fwd($sformatf("R3 R4 R8 R9 vec%0d forward", v), v + 1, h, VEC[v][6]);
      chk(irq == VEC[v][5], $sformatf("R5 R6 R7 vec%0d irq", v), {31'h0, irq}, {31'h0, VEC[v][5]});
      if (VEC[v][5]) begin have_copy = 1; last_id = v + 1; last_hdr = h; end
      check_buf($sformatf("R5 R7 R9 vec%0d buffer", v));
      pulse_clr();
      @(negedge clk);
      chk(!irq && !oam_ovr, "R6 irq cleared", {30'h0, irq, oam_ovr}, 0);
      @(posedge clk); #1;
    end

    // R12: stray bytes before a start-of-cell are ignored
    cfg_oam_check = 0; cfg_idle_discard = 0; cfg_hec_ignore = 0; flt_en = 0;
    got_n = 0;
    for (int i = 0; i < 3; i++) put_byte(8'hE0 + 8'(i), 1'b0, 1'b0);
    chk(got_n == 0, "R12 stray bytes dropped", 32'(got_n), 0);
    send_cell(20, 32'h0030_0100, 1'b0);
    check_fwd("R12 cell after stray bytes", 20, 32'h0030_0100, 1'b1);

    // R10: overrun when a second copy lands on a pending interrupt
    cfg_oam_check = 1;
    send_cell(30, 32'h0020_0040, 1'b0);
    chk(irq && !oam_ovr, "R10 first copy", {30'h0, irq, oam_ovr}, 2);
    send_cell(31, 32'h0020_0208, 1'b0);
    chk(irq && oam_ovr, "R10 overrun set", {30'h0, irq, oam_ovr}, 3);
    last_id = 31; last_hdr = 32'h0020_0208;
    check_buf("R10 buffer overwritten");
    pulse_clr();
    @(negedge clk);
    chk(!irq && !oam_ovr, "R10 overrun cleared", {30'h0, irq, oam_ovr}, 0);
    @(posedge clk); #1;

    // R11: dropped cell is taken even with the output stalled
    bp_mode = 2;
    @(posedge clk); #1;
    t0 = cyc;
    send_cell(40, 32'h0020_0030, 1'b0);
    chk((cyc - t0) <= 62, "R11 dropped cell not stalled", 32'(cyc - t0), 62);
    chk(got_n == 0 && irq, "R11 R5 dropped cell copied", {31'h0, irq}, 1);
    bp_mode = 0;
    pulse_clr();

    // R13: configuration change after the decision byte has no effect
    cfg_oam_check = 0;
    got_n = 0;
    for (int i = 0; i < 53; i++) begin
      if (i == 10) cfg_oam_check = 1;
      put_byte(exp_byte(41, 32'h0020_0040, i), i == 0, 1'b0);
    end
    repeat (3) @(posedge clk); #1;
    chk(!irq && got_n == 53, "R13 config sampled at header", {31'h0, irq}, 0);

    summary();
    $finish;
  end
endmodule